// File: doc/BRIEF.md
# Bidirectional I/O Port with Drive-Gap Control

This block controls a bank of general-purpose pins, eight by default. A small synchronous register bus sets each pin's direction and drive level. For every pin the block produces three signals for the pad: an output enable, an output level and a pull-up request. Writing a mask to the pin address inverts the selected output-data bits in a single bus cycle, so software does not need a read-modify-write sequence.

An optional port-wide mode prevents contention when a pin changes from input to output. When this mode is on, a pin whose direction bit has just become 1 stays in high impedance for one clock before it drives. A pin that changes from output to input stops driving at once in both modes. The incoming pad levels pass through a two-flop synchronizer and are read back at the pin address.

Top module: `gpio_bbm_port`

## Requirements
- R1: After reset, the direction, output-data and mode registers are all zero. Every `pad_oe` and `pad_pu` bit is 0, and reads of addresses 1, 2 and 3 return 0.
- R2: Each pin is controlled by the bit pair {direction, data}. 00 is an input with no pull-up. 01 is an input with a pull-up (`pad_pu`=1). 10 drives low and 11 drives high (`pad_oe`=1 with `pad_out` equal to the data bit). When a bit is 1 in `pad_oe`, it is 0 in `pad_pu`.
- R3: When `pullup_off` is 1, all `pad_pu` bits are 0. This takes effect combinationally and the stored registers are unchanged.
- R4: A write to address 0 inverts each output-data bit whose write-data bit is 1. Bits written with 0 keep their value. The direction value does not affect this.
- R5: The address map is: 1 is the direction register, 2 is the output-data register, and 3 is the mode register, where bit 0 enables the drive gap. Reads of addresses 1 and 2 return the stored value. A read of address 3 returns the mode bit in bit 0 and 0 in all other bits.
- R6: With the mode bit at 0, `pad_oe` equals the new direction value in the first cycle after the clock edge that stores a direction write.
- R7: With the mode bit at 1, in the first cycle after a direction write, `pad_oe` is 0 for every bit that changed from 0 to 1. All other bits take their new value. From the second cycle on, `pad_oe` equals the direction register.
- R8: A direction bit that changes from 1 to 0 clears its `pad_oe` bit in the first cycle after the write, in both modes.
- R9: A read of address 0 returns `pad_in` delayed by two clock edges. A level present at one edge is visible after the following edge.
- R10: When `bus_we` is 0, the register state does not change, whatever the values on `bus_addr` and `bus_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for `bus_addr` |
| pad_in | input | WIDTH | Raw pad levels |
| pullup_off | input | 1 | Global pull-up disable |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin output level |
| pad_pu | output | WIDTH | Per-pin pull-up enable |

## Verification
The encoding check covers every direction value. Each is paired with all-zero, all-one, alternating and complementary data patterns, with the pull-up disable both off and on. This separates the four pin states and shows whether the pull-up gating depends on direction, on data, or on both.

The drive-gap check covers every previous direction value. Each is written over with its complement, all ones, all zeros and a partial flip, in both modes. This shows whether only rising bits get the gap, whether the gap lasts exactly one cycle, and whether falling bits release at once.

Toggle masks cover all 256 values under several direction settings. The synchronizer check looks at the pin readback after one clock edge and after two, which pins down its latency.

// File: rtl/gpio_bbm_port.sv
module gpio_bbm_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  input  logic             pullup_off,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);
  localparam logic [1:0] A_PIN  = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_MODE = 2'd3;

  logic [WIDTH-1:0] dir_q, data_q, hold_q, sync1_q, sync2_q;
  logic             gap_en_q;

  wire wr_pin  = bus_we && bus_addr == A_PIN;
  wire wr_dir  = bus_we && bus_addr == A_DIR;
  wire wr_data = bus_we && bus_addr == A_DATA;
  wire wr_mode = bus_we && bus_addr == A_MODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      data_q   <= '0;
      hold_q   <= '0;
      gap_en_q <= 1'b0;
    end else begin
      hold_q <= '0;
      if (wr_dir) begin
        dir_q <= bus_wdata;
        if (gap_en_q) hold_q <= bus_wdata & ~dir_q;
      end
      if (wr_data)     data_q <= bus_wdata;
      else if (wr_pin) data_q <= data_q ^ bus_wdata;
      if (wr_mode) gap_en_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign pad_oe  = dir_q & ~hold_q;
  assign pad_out = data_q;
  assign pad_pu  = ~dir_q & data_q & {WIDTH{~pullup_off}};

  always_comb begin
    case (bus_addr)
      A_PIN:   bus_rdata = sync2_q;
      A_DIR:   bus_rdata = dir_q;
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = {{(WIDTH-1){1'b0}}, gap_en_q};
    endcase
  end

  assert_pu_oe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  assert_pu_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_off |-> pad_pu == '0);

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pin |=> data_q == ($past(data_q) ^ $past(bus_wdata)));

  assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && !gap_en_q) |=> pad_oe == $past(bus_wdata));

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && gap_en_q) |=> pad_oe == ($past(bus_wdata) & $past(dir_q)));

  assert_gap_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> pad_oe == dir_q);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pad_oe & ~$past(bus_wdata)) == '0);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(dir_q) && $stable(data_q) && $stable(gap_en_q));
endmodule

// File: tb/gpio_bbm_port_tb.sv
`timescale 1ns/1ps
module gpio_bbm_port_tb;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, bus_we = 0, pullup_off = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, pad_in = 0;
  logic [W-1:0] bus_rdata, pad_oe, pad_out, pad_pu;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bbm_port #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pullup_off(pullup_off), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] r, m, data_exp;
    logic [W-1:0] pats[6];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", pad_oe, '0);
    chk("R1 pu", pad_pu, '0);
    for (int a = 1; a < 4; a++) begin rd(a[1:0], r); chk("R1 read", r, '0); end

    // R2/R3/R5 encoding sweep
    for (int d = 0; d < 256; d++) begin
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55;
      pats[3] = 8'hAA; pats[4] = d[7:0]; pats[5] = ~d[7:0];
      wr(2'd1, d[7:0]);
      for (int p = 0; p < 6; p++) begin
        wr(2'd2, pats[p]);
        pullup_off = 0; #1;
        chk("R2 oe", pad_oe, d[7:0]);
        chk("R2 out", pad_oe & pad_out, d[7:0] & pats[p]);
        chk("R2 pu", pad_pu, ~d[7:0] & pats[p]);
        pullup_off = 1; #1;
        chk("R3 pu off", pad_pu, '0);
        rd(2'd2, r); chk("R3 data kept / R5 data read", r, pats[p]);
        pullup_off = 0;
      end
      rd(2'd1, r); chk("R5 dir read", r, d[7:0]);
    end

    // R5 mode register read
    wr(2'd3, 8'hFF); rd(2'd3, r); chk("R5 mode read", r, 8'h01);
    wr(2'd3, 8'hFE); rd(2'd3, r); chk("R5 mode clear", r, 8'h00);

    // R6/R7/R8 drive gap sweep
    for (int g = 0; g < 2; g++) begin
      wr(2'd3, g[7:0]);
      for (int o = 0; o < 256; o++) begin
        pats[0] = ~o[7:0]; pats[1] = 8'hFF; pats[2] = 8'h00; pats[3] = o[7:0] ^ 8'h0F;
        for (int p = 0; p < 4; p++) begin
          wr(2'd1, o[7:0]);
          @(negedge clk);
          wr(2'd1, pats[p]);
          if (g == 1) chk("R7 gap cycle", pad_oe, pats[p] & o[7:0]);
          else        chk("R6 follow", pad_oe, pats[p]);
          chk("R8 release", pad_oe & ~pats[p], '0);
          @(negedge clk);
          chk("R7 settled", pad_oe, pats[p]);
        end
      end
    end
    wr(2'd3, 8'h00);

    // R4 toggle sweep
    wr(2'd2, 8'h00); data_exp = 8'h00;
    for (int t = 0; t < 256; t++) begin
      if (t % 64 == 0) wr(2'd1, t[7:0] ^ 8'h3C);
      wr(2'd0, t[7:0]);
      data_exp = data_exp ^ t[7:0];
      rd(2'd2, r); chk("R4 toggle", r, data_exp);
    end
    wr(2'd0, 8'h00); rd(2'd2, r); chk("R4 zero mask", r, data_exp);

    // R10 no write when strobe low
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); bus_addr = a[1:0]; bus_wdata = 8'h5A; bus_we = 0;
      @(negedge clk);
    end
    rd(2'd1, r); chk("R10 dir", r, 8'hA5);
    rd(2'd2, r); chk("R10 data", r, 8'h3C);
    rd(2'd3, r); chk("R10 mode", r, 8'h00);
    chk("R10 oe", pad_oe, 8'hA5);

    // R9 synchronizer latency
    for (int v = 0; v < 256; v += 17) begin
      @(negedge clk); pad_in = 8'h00;
      repeat (3) @(negedge clk);
      pad_in = v[7:0];
      @(negedge clk); rd(2'd0, m);
      chk("R9 one edge", m, 8'h00);
      @(negedge clk); rd(2'd0, m);
      chk("R9 two edges", m, v[7:0]);
    end

    done = 1;
    finish_run();
  end
endmodule